// File: doc/BRIEF.md
# Vector Lane Integer Divider

The block divides two 128-bit source vectors lane by lane. It forms either four 32-bit lanes or two 64-bit lanes. A packed 11-bit minor operation field picks the operation and whether it is signed. The operations are plain division, extended division and modulo. In extended division the lane dividend is scaled up by the lane width before dividing, and only the low lane-width bits of the quotient are kept.

Every lane runs its own restoring divider, which produces one quotient bit per clock. All lanes step together. Division by zero and the signed overflow case give fixed, defined results, so a lane never holds garbage. A caller pulses `start_i` while the unit is idle and waits for the one-cycle `done_o`. The 128-bit result is registered at that point and held until the next completion. An operation field with no meaning is refused at once with `illegal_o`, and no work starts.

Top module: `vdiv_unit`

## Requirements
- R1: `op_i[5:0]` must equal 6'b001011. `op_i[10:9]` selects the operation: 2'b00 divide, 2'b01 extended divide, 2'b11 modulo. `op_i[8]` set means signed. `op_i[7:6]` set to 2'b10 gives four 32-bit lanes and 2'b11 gives two 64-bit lanes. Lane i of a W-bit layout occupies bits [W*i +: W] of the operands and of the result, and each lane depends only on its own slices.
- R2: Any other value of `op_i` at an idle start raises `illegal_o` for exactly the next cycle. `busy_o` stays low and `result_o` keeps its value.
- R3: Divide returns the lane quotient. Signed divide truncates toward zero.
- R4: Modulo returns the lane remainder. A signed remainder carries the sign of the dividend.
- R5: Extended divide returns the low W bits of (dividend * 2^W) / divisor, computed signed or unsigned as selected.
- R6: A zero divisor in a lane is treated as 1. Divide then returns the dividend, modulo returns 0, and extended word divide returns 0.
- R7: In a signed operation, a dividend equal to the most negative value with a divisor of all ones is also treated as division by 1, with the same results as R6.
- R8: In an extended doubleword divide, a lane hit by R6 or R7 returns its original dividend.
- R9: After an accepted start, `busy_o` is high from the next cycle. `done_o` pulses for one cycle exactly N+1 cycles after the start edge, where N is W for divide and modulo and 2W for extended divide. `busy_o` falls in the same cycle that `done_o` rises.
- R10: `start_i` is ignored while `busy_o` is high, whatever `op_i` holds.
- R11: Reset clears `busy_o`, `done_o`, `illegal_o` and `result_o`. `result_o` changes only when `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start an operation |
| op_i | input | 11 | Packed minor operation field |
| a_i | input | 128 | Dividend vector |
| b_i | input | 128 | Divisor vector |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle reject pulse for an unusable operation field |
| result_o | output | 128 | Registered result vector |

## Verification
The assertions assume that reset is held low across at least one rising edge. They also assume that `op_i` and the operands matter only in the cycle where `start_i` is seen while idle. Nothing requires them to stay stable afterwards, so the stimulus changes them freely once the start is taken. The stimulus drives every input on falling edges. It holds `start_i` for one cycle per request, and on purpose pulses it during busy periods with both legal and illegal fields.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
  localparam int unsigned DW     = 64;
  localparam int unsigned WW     = DW / 2;
  localparam int unsigned VEC_W  = 2 * DW;
  localparam int unsigned N_LANE = VEC_W / WW;
  localparam int unsigned N_DW   = VEC_W / DW;
  localparam int unsigned CNT_W  = $clog2(2 * DW + 1);
  localparam logic [5:0]  MINOR_TAG = 6'b001011;

  typedef enum logic [1:0] {
    K_DIV = 2'b00,
    K_EXT = 2'b01,
    K_BAD = 2'b10,
    K_MOD = 2'b11
  } kind_e;

  typedef struct packed {
    logic  legal;
    kind_e kind;
    logic  sgn;
    logic  dword;
  } dec_t;
endpackage

// File: rtl/vdiv_decode.sv
module vdiv_decode
  import vdiv_pkg::*;
(
  input  logic [10:0] op_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.kind  = kind_e'(op_i[10:9]);
    dec_o.sgn   = op_i[8];
    dec_o.dword = op_i[6];
    dec_o.legal = (op_i[5:0] == MINOR_TAG) && (op_i[10:9] != K_BAD) && op_i[7];
  end
endmodule

// File: rtl/vdiv_lane_prep.sv
module vdiv_lane_prep #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sgn_i,
  input  logic         dword_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_q_o,
  output logic         neg_r_o,
  output logic         undef_o
);
  localparam int unsigned HW = W / 2;

  logic         sa, sb, a_min, b_m1, b_zero;
  logic [W-1:0] a_x, b_x, ma, mb;

  always_comb begin
    sa     = sgn_i & (dword_i ? a_i[W-1] : a_i[HW-1]);
    sb     = sgn_i & (dword_i ? b_i[W-1] : b_i[HW-1]);
    b_zero = dword_i ? (b_i == '0) : (b_i[HW-1:0] == '0);
    a_min  = dword_i ? (a_i == {1'b1, {(W-1){1'b0}}})
                     : (a_i[HW-1:0] == {1'b1, {(HW-1){1'b0}}});
    b_m1   = dword_i ? (&b_i) : (&b_i[HW-1:0]);
    undef_o = b_zero | (sgn_i & a_min & b_m1);

    a_x = dword_i ? a_i : {{HW{sa}}, a_i[HW-1:0]};
    b_x = dword_i ? b_i : {{HW{sb}}, b_i[HW-1:0]};
    ma  = sa ? -a_x : a_x;
    mb  = undef_o ? W'(1) : (sb ? -b_x : b_x);

    mag_a_o = dword_i ? ma : {{HW{1'b0}}, ma[HW-1:0]};
    mag_b_o = dword_i ? mb : {{HW{1'b0}}, mb[HW-1:0]};
    // substituted divisor is +1, so only the dividend sign survives
    neg_q_o = undef_o ? sa : (sa ^ sb);
    neg_r_o = sa;
  end
endmodule

// File: rtl/vdiv_lane_eng.sv
module vdiv_lane_eng #(
  parameter int unsigned W = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o
);
  logic [2*W-1:0] dvd_q;
  logic [W-1:0]   dvs_q, quo_q, rem_q;
  logic [W:0]     part, diff;
  logic           take;

  always_comb begin
    part = {rem_q, dvd_q[2*W-1]};
    diff = part - {1'b0, dvs_q};
    take = (part >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      dvd_q <= dvd_i;
      dvs_q <= dvs_i;
      quo_q <= '0;
      rem_q <= '0;
    end else if (step_i) begin
      dvd_q <= {dvd_q[2*W-2:0], 1'b0};
      quo_q <= {quo_q[W-2:0], take};
      rem_q <= take ? diff[W-1:0] : part[W-1:0];
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/vdiv_lane_post.sv
module vdiv_lane_post
  import vdiv_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] a_raw_i,
  input  kind_e        kind_i,
  input  logic         dword_i,
  input  logic         neg_q_i,
  input  logic         neg_r_i,
  input  logic         undef_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned HW = W / 2;

  logic [W-1:0] val, sv;
  logic         neg;

  always_comb begin
    val = (kind_i == K_MOD) ? rem_i : quo_i;
    neg = (kind_i == K_MOD) ? neg_r_i : neg_q_i;
    sv  = neg ? -val : val;
    if (kind_i == K_EXT && dword_i && undef_i) sv = a_raw_i;
    res_o = dword_i ? sv : {{HW{1'b0}}, sv[HW-1:0]};
  end
endmodule

// File: rtl/vdiv_unit.sv
module vdiv_unit
  import vdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [10:0]      op_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             illegal_o,
  output logic [VEC_W-1:0] result_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

  dec_t             dec;
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q, n_load;
  kind_e            kind_q;
  logic             dword_q;
  logic             accept, run;
  logic [VEC_W-1:0] res_w, res_d, res;

  vdiv_decode u_dec (.op_i(op_i), .dec_o(dec));

  assign accept = (st_q == S_IDLE) & start_i & dec.legal;
  assign run    = (st_q == S_RUN);
  assign busy_o = (st_q != S_IDLE);

  always_comb begin
    n_load = dec.dword ? CNT_W'(DW) : CNT_W'(WW);
    if (dec.kind == K_EXT) n_load = n_load << 1;
  end

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    logic [DW-1:0]   la, lb, mag_a, mag_b, quo, rem, la_q, lane_res;
    logic [2*DW-1:0] dvd;
    logic            neg_q, neg_r, undef, neg_q_q, neg_r_q, undef_q;

    if (l < N_DW) begin : g_wide
      assign la = dec.dword ? a_i[l*DW +: DW] : {{WW{1'b0}}, a_i[l*WW +: WW]};
      assign lb = dec.dword ? b_i[l*DW +: DW] : {{WW{1'b0}}, b_i[l*WW +: WW]};
    end else begin : g_narrow
      assign la = dec.dword ? '0 : {{WW{1'b0}}, a_i[l*WW +: WW]};
      assign lb = dec.dword ? '0 : {{WW{1'b0}}, b_i[l*WW +: WW]};
    end

    vdiv_lane_prep #(.W(DW)) u_prep (
      .a_i(la), .b_i(lb), .sgn_i(dec.sgn), .dword_i(dec.dword),
      .mag_a_o(mag_a), .mag_b_o(mag_b),
      .neg_q_o(neg_q), .neg_r_o(neg_r), .undef_o(undef)
    );

    // left-align the effective dividend so the first step sees its MSB
    assign dvd = dec.dword ? {mag_a, {DW{1'b0}}}
                           : {mag_a[WW-1:0], {(2*DW-WW){1'b0}}};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        la_q    <= '0;
        neg_q_q <= 1'b0;
        neg_r_q <= 1'b0;
        undef_q <= 1'b0;
      end else if (accept) begin
        la_q    <= la;
        neg_q_q <= neg_q;
        neg_r_q <= neg_r;
        undef_q <= undef;
      end
    end

    vdiv_lane_eng #(.W(DW)) u_eng (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .step_i(run),
      .dvd_i(dvd), .dvs_i(mag_b), .quo_o(quo), .rem_o(rem)
    );

    vdiv_lane_post #(.W(DW)) u_post (
      .quo_i(quo), .rem_i(rem), .a_raw_i(la_q), .kind_i(kind_q),
      .dword_i(dword_q), .neg_q_i(neg_q_q), .neg_r_i(neg_r_q),
      .undef_i(undef_q), .res_o(lane_res)
    );

    assign res_w[l*WW +: WW] = lane_res[WW-1:0];
    if (l < N_DW) begin : g_dres
      assign res_d[l*DW +: DW] = lane_res;
    end
  end

  assign res = dword_q ? res_d : res_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      kind_q    <= K_DIV;
      dword_q   <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            if (dec.legal) begin
              st_q    <= S_RUN;
              cnt_q   <= n_load;
              kind_q  <= dec.kind;
              dword_q <= dec.dword;
            end else begin
              illegal_o <= 1'b1;
            end
          end
        end
        S_RUN: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_q <= S_FIN;
        end
        S_FIN: begin
          st_q     <= S_IDLE;
          done_o   <= 1'b1;
          result_o <= res;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vdiv_unit_chk.sv
module vdiv_unit_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         illegal_o,
  input logic [127:0] result_o
);
  // R2
  illegal_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !busy_o);

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  busy_fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  // R10
  busy_start_no_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !illegal_o);

  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
endmodule

bind vdiv_unit vdiv_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .illegal_o(illegal_o), .result_o(result_o)
);

// File: tb/vdiv_unit_test.sv
`timescale 1ns/1ps
module vdiv_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [10:0]  op = '0;
  logic [127:0] a = '0, b = '0;
  logic         busy, done, illegal;
  logic [127:0] result;

  vdiv_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .busy_o(busy), .done_o(done), .illegal_o(illegal), .result_o(result)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit live = 0, ended = 0;
  string cur_tag = "R1";

  logic         m_busy = 0, m_done = 0, m_ill = 0;
  int           m_cnt = 0;
  logic [127:0] m_res = '0, m_pend = '0;
  string        m_tag = "R11";

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] mkop(input logic [1:0] k, input bit s, input bit d);
    return {k, s, 1'b1, d, 6'b001011};
  endfunction

  function automatic bit is_legal(input logic [10:0] o);
    return o[5:0] == 6'b001011 && o[10:9] != 2'b10 && o[7];
  endfunction

  function automatic int lat(input logic [10:0] o);
    return (o[6] ? 64 : 32) * (o[10:9] == 2'b01 ? 2 : 1);
  endfunction

  function automatic logic [63:0] ref_lane(input int w, input bit sgn, input logic [1:0] k,
                                           input logic [63:0] av, input logic [63:0] bv);
    logic signed [127:0] sa, sb;
    logic [127:0] ua, ub, uq, mask;
    bit undef;
    mask = (128'd1 << w) - 1;
    ua = {64'd0, av} & mask;
    ub = {64'd0, bv} & mask;
    sa = ua;
    sb = ub;
    if (sgn && ua[w-1]) sa = ua - (128'd1 << w);
    if (sgn && ub[w-1]) sb = ub - (128'd1 << w);
    undef = (ub == 0) || (sgn && ua == (128'd1 << (w-1)) && ub == mask);
    uq = '0;
    case (k)
      2'b00: if (undef) uq = ua; else if (sgn) uq = sa / sb; else uq = ua / ub;
      2'b11: if (undef) uq = '0; else if (sgn) uq = sa % sb; else uq = ua % ub;
      default: begin
        if (undef) uq = (w == 64) ? ua : '0;
        else if (sgn) uq = (sa <<< w) / sb;
        else uq = (ua << w) / ub;
      end
    endcase
    uq = uq & mask;
    return uq[63:0];
  endfunction

  function automatic logic [127:0] ref_vec(input logic [10:0] o, input logic [127:0] x,
                                           input logic [127:0] y);
    logic [127:0] r;
    r = '0;
    if (o[6]) begin
      for (int l = 0; l < 2; l++)
        r[l*64 +: 64] = ref_lane(64, o[8], o[10:9], x[l*64 +: 64], y[l*64 +: 64]);
    end else begin
      for (int l = 0; l < 4; l++) begin
        logic [63:0] t;
        t = ref_lane(32, o[8], o[10:9], {32'd0, x[l*32 +: 32]}, {32'd0, y[l*32 +: 32]});
        r[l*32 +: 32] = t[31:0];
      end
    end
    return r;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ill = 0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 0;
      m_ill  = 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy = 0; m_done = 1; m_res = m_pend;
        end else m_cnt--;
      end else if (start) begin
        if (is_legal(op)) begin
          m_busy = 1; m_cnt = lat(op) + 1; m_pend = ref_vec(op, a, b); m_tag = cur_tag;
        end else m_ill = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (live && !ended) begin
      chk("R9 busy", {127'd0, busy}, {127'd0, m_busy});
      chk("R9 done", {127'd0, done}, {127'd0, m_done});
      chk("R2 illegal", {127'd0, illegal}, {127'd0, m_ill});
      chk(m_done ? m_tag : "R11 hold", result, m_res);
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic issue(input logic [10:0] o, input logic [127:0] x, input logic [127:0] y,
                       input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    op = o; a = x; b = y; start = 1'b1; cur_tag = tag;
    @(negedge clk);
    start = 1'b0;
    op = $urandom; a = {4{$urandom}};
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset busy/done/illegal", {125'd0, busy, done, illegal}, '0);
    chk("R11 reset result", result, '0);
    rst_n = 1'b1;
    live = 1;

    // R3 divide
    issue(mkop(2'b00, 0, 0), {32'd100, 32'd7, 32'hFFFFFFFF, 32'd50}, {32'd7, 32'd7, 32'd2, 32'd51}, "R3");
    issue(mkop(2'b00, 1, 0), {32'hFFFFFFF9, 32'd7, 32'hFFFFFF9C, 32'h80000000},
          {32'd2, 32'hFFFFFFFE, 32'hFFFFFFF9, 32'd3}, "R3");
    issue(mkop(2'b00, 0, 1), {64'hFFFF_FFFF_FFFF_FFFF, 64'd1000}, {64'd3, 64'd33}, "R3");
    issue(mkop(2'b00, 1, 1), {-64'sd1001, 64'sd1001}, {64'sd10, -64'sd10}, "R3");
    // R4 modulo
    issue(mkop(2'b11, 1, 0), {32'hFFFFFFF9, 32'd7, 32'hFFFFFF9C, 32'd100},
          {32'd2, 32'hFFFFFFFE, 32'd7, 32'hFFFFFFF9}, "R4");
    issue(mkop(2'b11, 0, 0), {32'hFFFFFFFF, 32'd7, 32'd99, 32'd5}, {32'd10, 32'd7, 32'd100, 32'd3}, "R4");
    issue(mkop(2'b11, 1, 1), {-64'sd1001, 64'sd1001}, {64'sd10, -64'sd10}, "R4");
    issue(mkop(2'b11, 0, 1), {64'hFFFF_FFFF_FFFF_FFFF, 64'd12345}, {64'h1_0000_0000, 64'd100}, "R4");
    // R5 extended divide
    issue(mkop(2'b01, 0, 0), {32'd1, 32'd3, 32'd5, 32'h7FFFFFFF}, {32'd3, 32'd7, 32'hFFFFFFFF, 32'h80000000}, "R5");
    issue(mkop(2'b01, 1, 0), {32'hFFFFFFFF, 32'd1, 32'hFFFFFFFD, 32'd5}, {32'd3, 32'hFFFFFFFD, 32'hFFFFFFF9, 32'd2}, "R5");
    issue(mkop(2'b01, 0, 1), {64'd1, 64'd5}, {64'd3, 64'hFFFF_FFFF_FFFF_FFFF}, "R5");
    issue(mkop(2'b01, 1, 1), {-64'sd1, 64'sd7}, {64'sd3, -64'sd9}, "R5");
    // R6 zero divisor across operations
    issue(mkop(2'b00, 1, 0), {32'hFFFFFFF9, 32'd7, 32'd0, 32'h80000000}, '0, "R6");
    issue(mkop(2'b11, 0, 1), {64'd77, 64'hDEAD}, '0, "R6");
    issue(mkop(2'b01, 1, 0), {32'hFFFFFFF9, 32'd7, 32'd1, 32'h80000000}, '0, "R6");
    issue(mkop(2'b00, 0, 1), {64'd0, 64'h1234}, {64'd0, 64'd0}, "R6");
    // R7 most negative by minus one
    issue(mkop(2'b00, 1, 0), {4{32'h80000000}}, {32'hFFFFFFFF, 32'd1, 32'hFFFFFFFF, 32'd2}, "R7");
    issue(mkop(2'b11, 1, 0), {4{32'h80000000}}, {4{32'hFFFFFFFF}}, "R7");
    issue(mkop(2'b01, 1, 0), {2{32'h80000000, 32'h7FFFFFFF}}, {4{32'hFFFFFFFF}}, "R7");
    issue(mkop(2'b00, 1, 1), {2{64'h8000_0000_0000_0000}}, {64'd2, -64'sd1}, "R7");
    issue(mkop(2'b00, 0, 0), {4{32'h80000000}}, {4{32'hFFFFFFFF}}, "R7");
    // R8 extended doubleword undefined lanes
    issue(mkop(2'b01, 1, 1), {64'h8000_0000_0000_0000, 64'hABCD}, {-64'sd1, 64'd0}, "R8");
    issue(mkop(2'b01, 0, 1), {64'h8000_0000_0000_0000, 64'h55}, {64'hFFFF_FFFF_FFFF_FFFF, 64'd0}, "R8");

    // R2 illegal fields, result must stay put
    begin
      logic [10:0] bad [4];
      bad[0] = {2'b10, 1'b0, 2'b10, 6'b001011};
      bad[1] = {2'b00, 1'b0, 2'b00, 6'b001011};
      bad[2] = {2'b11, 1'b1, 2'b01, 6'b001011};
      bad[3] = {2'b00, 1'b0, 2'b10, 6'b001010};
      for (int i = 0; i < 4; i++) begin
        issue(bad[i], {4{$urandom}}, {4{$urandom}}, "R2");
        chk("R2 result unchanged", result, m_res);
      end
    end

    // R10 start while busy
    @(negedge clk);
    op = mkop(2'b00, 0, 0); a = {32'd40, 32'd30, 32'd20, 32'd10}; b = {4{32'd3}};
    start = 1'b1; cur_tag = "R10";
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    op = mkop(2'b11, 1, 1); a = {4{32'hFFFF}}; b = {4{32'd7}}; start = 1'b1;
    @(negedge clk);
    op = 11'h7FF;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk("R10 first result kept", result, ref_vec(mkop(2'b00, 0, 0), {32'd40, 32'd30, 32'd20, 32'd10}, {4{32'd3}}));

    // R1 random legal operations, independent lanes
    for (int i = 0; i < 48; i++) begin
      logic [1:0]   k;
      logic [127:0] x, y;
      int           sel;
      sel = $urandom_range(2);
      k = (sel == 0) ? 2'b00 : (sel == 1) ? 2'b01 : 2'b11;
      x = {$urandom, $urandom, $urandom, $urandom};
      y = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(2) == 0) y = y & {4{32'h0000_00FF}};
      if ($urandom_range(5) == 0) y[31:0] = '0;
      issue(mkop(k, 1'($urandom_range(1)), 1'($urandom_range(1))), x, y, "R1");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule